// File: doc/BRIEF.md
# Error Status Reporting Register

This block is the sticky error status word of a memory controller. The controller's datapaths send one-cycle event pulses for a fixed set of fault conditions. These are a locked host cycle to non-DRAM memory, a target-aborted outbound cycle, an unimplemented special cycle, three graphics aperture faults, and correctable and uncorrectable ECC read errors. Each pulse sets a flag in a 16-bit word. Software reads that word and clears flags by writing ones. Flags set whether or not any reporting is enabled.

Three enable masks are used: system error, management interrupt and configuration interrupt. They decide which flags may raise a message request. A request is raised only when a flag goes from 0 to 1 and its bit is enabled in the matching mask. Each request output is a one-cycle pulse.

ECC events carry an address and a device tag, which are kept in an error-address log. An uncorrectable error freezes the log until software clears that flag. This keeps the first uncorrectable failure available for diagnosis.

Top module: `errstat_reg`

## Requirements
- R1: After reset the status word reads 0x0000, all three request outputs are 0, and the logged address and device are 0.
- R2: Event input bit k sets status bit k for the implemented positions 9, 6, 5, 4, 3, 2, 1 and 0. Bit 1 is the uncorrectable (multi-bit) ECC flag and bit 0 is the correctable (single-bit) ECC flag. Bits 15:10 and 8:7 always read 0, and events on those positions are ignored.
- R3: A write clears every implemented flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: A flag stays set until it is cleared by a write. It sets whatever the three enable masks hold.
- R5: When an event and a write-one-to-clear hit the same bit in the same cycle, the flag is set afterwards. If the flag was already set, no request is raised.
- R6: Each request output (system error, management interrupt, configuration interrupt) pulses high for one cycle, in the cycle after an event turns a flag from 0 to 1. It pulses only if that bit is 1 in its own enable mask. Several qualifying edges in one cycle give one pulse. An event on a flag that is already set gives no pulse.
- R7: An uncorrectable ECC event captures its address and device into the log when bit 1 is clear, replacing any correctable entry. While bit 1 is set the log does not change. After bit 1 is cleared, logging resumes.
- R8: A correctable ECC event captures the log only when bit 1 is clear and no uncorrectable event occurs in the same cycle. A later correctable event replaces an earlier correctable entry.
- R9: Event and write effects are visible on the read data and log outputs one clock after the cycle in which they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 16 | One-cycle error event pulses, one bit per status position |
| ecc_addr | input | ADDR_W | Failing address accompanying an ECC event |
| ecc_dev | input | DEV_W | Failing device number accompanying an ECC event |
| reg_wr | input | 1 | Write strobe for write-one-to-clear |
| reg_wdata | input | 16 | Write data; ones clear the matching flags |
| reg_rdata | output | 16 | Current status word |
| serr_en | input | 16 | System error enable mask |
| smi_en | input | 16 | Management interrupt enable mask |
| sci_en | input | 16 | Configuration interrupt enable mask |
| serr_req | output | 1 | System error message request pulse |
| smi_req | output | 1 | Management interrupt message request pulse |
| sci_req | output | 1 | Configuration interrupt message request pulse |
| log_addr | output | ADDR_W | Logged ECC error address |
| log_dev | output | DEV_W | Logged ECC error device |

## Verification
The bound checker checks the following on every cycle: reserved bits stay zero, cleared bits drop, and bits that are set or just hit by an event stay set. It also checks that each request pulse matches exactly the enabled 0-to-1 transitions of the status word, that the log is frozen while the uncorrectable flag is set, and that captures follow the correctable and uncorrectable rules. Some behaviours can only be shown by the bench's scenarios and its cycle-accurate reference model. These are the ordering of entries across a correctable, uncorrectable, second uncorrectable and clear sequence, the same-cycle race between an event and a clear, the independence of the three masks, and long sparse random traffic.

// File: rtl/errstat_pkg.sv
// Package: shared constants for the error status register.
// Assumes a fixed 16-bit status word whose implemented bit positions are
// decoded by software, so the positions below are behaviour, not layout.
package errstat_pkg;
    localparam int unsigned STAT_W    = 16;
    localparam int unsigned NUM_MSG   = 3;
    localparam logic [STAT_W-1:0] IMPL_MASK = 16'h027F;
    localparam int unsigned MBE_BIT   = 1;
    localparam int unsigned SBE_BIT   = 0;

    typedef enum logic [1:0] {
        MSG_SERR = 2'd0,
        MSG_SMI  = 2'd1,
        MSG_SCI  = 2'd2
    } msg_kind_e;
endpackage

// File: rtl/errstat_flag_bank.sv
// Module: sticky flag bank with write-one-to-clear.
// Holds the implemented flags, applies clears and sets in one step with the
// set taking priority, and reports which flags go from 0 to 1 this cycle.
// Assumes event pulses are one cycle wide and synchronous to clk.
module errstat_flag_bank #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] flags,
    output logic [W-1:0] rise
);
    logic [W-1:0] evt_q;
    logic [W-1:0] clr_q;
    logic [W-1:0] flags_nx;

    // Mask inputs to implemented positions only.
    always_comb begin
        evt_q = evt & IMPL;
        clr_q = clr_wr ? (clr_data & IMPL) : '0;
    end

    // Per-bit next state: clear first, then set, so the event wins.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            if (IMPL[gi]) begin : g_impl
                assign flags_nx[gi] = (flags[gi] & ~clr_q[gi]) | evt_q[gi];
                assign rise[gi]     = evt_q[gi] & ~flags[gi];
            end else begin : g_rsvd
                assign flags_nx[gi] = 1'b0;
                assign rise[gi]     = 1'b0;
            end
        end
    endgenerate

    // Flag storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nx;
    end
endmodule

// File: rtl/errstat_msg_gen.sv
// Module: message request generator.
// One registered pulse per message kind, raised when any rising flag edge
// is enabled in that kind's mask. Assumes rise is already edge-qualified.
module errstat_msg_gen #(
    parameter int unsigned W = 16,
    parameter int unsigned N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        rise,
    input  logic [N-1:0][W-1:0] en,
    output logic [N-1:0]        req
);
    genvar gk;
    generate
        for (gk = 0; gk < N; gk++) begin : g_msg
            logic hit;
            // Any enabled edge for this message kind.
            assign hit = |(rise & en[gk]);
            // Register the request into a one-cycle pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) req[gk] <= 1'b0;
                else        req[gk] <= hit;
            end
        end
    endgenerate
endmodule

// File: rtl/errstat_err_log.sv
// Module: ECC error address log.
// Captures address and device on an uncorrectable error when unlocked,
// or on a correctable error when unlocked and no uncorrectable error is in
// the same cycle. Locked while the uncorrectable flag is set.
module errstat_err_log #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_evt,
    input  logic              mbe_evt,
    input  logic              mbe_flag,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DEV_W-1:0]  dev_in,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DEV_W-1:0]  log_dev
);
    logic capture;

    // Decide whether this cycle's ECC event may write the log.
    always_comb begin
        capture = !mbe_flag && (mbe_evt || sbe_evt);
    end

    // Log storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_addr <= '0;
            log_dev  <= '0;
        end else if (capture) begin
            log_addr <= addr_in;
            log_dev  <= dev_in;
        end
    end
endmodule

// File: rtl/errstat_reg.sv
// Module: error status reporting register (top).
// Ties the flag bank, message generator and ECC log together and exposes
// the status word for read. Assumes the register decode outside produces
// reg_wr only for writes addressed to this word.
module errstat_reg
    import errstat_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       evt_in,
    input  logic [ADDR_W-1:0] ecc_addr,
    input  logic [DEV_W-1:0]  ecc_dev,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [15:0]       serr_en,
    input  logic [15:0]       smi_en,
    input  logic [15:0]       sci_en,
    output logic              serr_req,
    output logic              smi_req,
    output logic              sci_req,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DEV_W-1:0]  log_dev
);
    logic [STAT_W-1:0]              flags;
    logic [STAT_W-1:0]              rise;
    logic [NUM_MSG-1:0][STAT_W-1:0] en_all;
    logic [NUM_MSG-1:0]             req_all;

    // Gather the three masks in message-kind order.
    always_comb begin
        en_all[MSG_SERR] = serr_en;
        en_all[MSG_SMI]  = smi_en;
        en_all[MSG_SCI]  = sci_en;
    end

    errstat_flag_bank #(.W(STAT_W), .IMPL(IMPL_MASK)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_in),
        .clr_wr   (reg_wr),
        .clr_data (reg_wdata),
        .flags    (flags),
        .rise     (rise)
    );

    errstat_msg_gen #(.W(STAT_W), .N(NUM_MSG)) u_msg (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .en    (en_all),
        .req   (req_all)
    );

    errstat_err_log #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .sbe_evt  (evt_in[SBE_BIT]),
        .mbe_evt  (evt_in[MBE_BIT]),
        .mbe_flag (flags[MBE_BIT]),
        .addr_in  (ecc_addr),
        .dev_in   (ecc_dev),
        .log_addr (log_addr),
        .log_dev  (log_dev)
    );

    // Drive the outward-facing read data and requests.
    always_comb begin
        reg_rdata = flags;
        serr_req  = req_all[MSG_SERR];
        smi_req   = req_all[MSG_SMI];
        sci_req   = req_all[MSG_SCI];
    end
endmodule

// File: rtl/errstat_reg_chk.sv
// Module: assertion checker for errstat_reg, attached by bind below.
// Observes only the top-level ports.
module errstat_reg_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEV_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       evt_in,
    input logic [ADDR_W-1:0] ecc_addr,
    input logic [DEV_W-1:0]  ecc_dev,
    input logic              reg_wr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic [15:0]       serr_en,
    input logic [15:0]       smi_en,
    input logic [15:0]       sci_en,
    input logic              serr_req,
    input logic              smi_req,
    input logic              sci_req,
    input logic [ADDR_W-1:0] log_addr,
    input logic [DEV_W-1:0]  log_dev
);
    localparam logic [15:0] IMPL = errstat_pkg::IMPL_MASK;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~IMPL) == 16'h0);                                        // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ((reg_rdata & $past(reg_wdata & ~evt_in & IMPL)) == 16'h0)); // R3

    AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ((reg_rdata & $past(reg_rdata & ~reg_wdata))
                    == $past(reg_rdata & ~reg_wdata)));                        // R3

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_in & IMPL) != 16'h0) |=> ((reg_rdata & $past(evt_in & IMPL))
                                        == $past(evt_in & IMPL)));             // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && ((evt_in & IMPL) == 16'h0)) |=> $stable(reg_rdata));      // R4

    AST_SERR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req == ((reg_rdata & ~$past(reg_rdata) & $past(serr_en)) != 16'h0)); // R6

    AST_SMI_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req == ((reg_rdata & ~$past(reg_rdata) & $past(smi_en)) != 16'h0)); // R6

    AST_SCI_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        sci_req == ((reg_rdata & ~$past(reg_rdata) & $past(sci_en)) != 16'h0)); // R6

    AST_LOG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1] |=> ($stable(log_addr) && $stable(log_dev)));             // R7

    AST_MBE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in[1] && !reg_rdata[1]) |=> (log_addr == $past(ecc_addr)
                                           && log_dev == $past(ecc_dev)));     // R7

    AST_SBE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in[0] && !evt_in[1] && !reg_rdata[1]) |=>
            (log_addr == $past(ecc_addr) && log_dev == $past(ecc_dev)));       // R8
endmodule

bind errstat_reg errstat_reg_chk #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .ecc_addr  (ecc_addr),
    .ecc_dev   (ecc_dev),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .serr_en   (serr_en),
    .smi_en    (smi_en),
    .sci_en    (sci_en),
    .serr_req  (serr_req),
    .smi_req   (smi_req),
    .sci_req   (sci_req),
    .log_addr  (log_addr),
    .log_dev   (log_dev)
);

// File: tb/errstat_reg_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module errstat_reg_test;
    localparam int AW = 32;
    localparam int DW = 4;
    localparam logic [15:0] IMPL_BITS = 16'h027F; // positions 9,6..0 per R2

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   evt_in = '0;
    logic [AW-1:0] ecc_addr = '0;
    logic [DW-1:0] ecc_dev = '0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [15:0]   serr_en = '0, smi_en = '0, sci_en = '0;
    logic          serr_req, smi_req, sci_req;
    logic [AW-1:0] log_addr;
    logic [DW-1:0] log_dev;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    errstat_reg #(.ADDR_W(AW), .DEV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ecc_addr(ecc_addr),
        .ecc_dev(ecc_dev), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr_en(serr_en), .smi_en(smi_en),
        .sci_en(sci_en), .serr_req(serr_req), .smi_req(smi_req),
        .sci_req(sci_req), .log_addr(log_addr), .log_dev(log_dev)
    );

    // Reference model state.
    logic [15:0]   m_flags = '0;
    logic [2:0]    m_req = '0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_dev = '0;
    logic [15:0]   t_e, t_rise, t_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags <= '0; m_req <= '0; m_addr <= '0; m_dev <= '0;
        end else begin
            t_e    = evt_in & IMPL_BITS;
            t_rise = t_e & ~m_flags;
            t_clr  = reg_wr ? reg_wdata : 16'h0;
            m_req  <= {|(t_rise & sci_en), |(t_rise & smi_en), |(t_rise & serr_en)};
            if (!m_flags[1] && (t_e[1] || t_e[0])) begin
                m_addr <= ecc_addr; m_dev <= ecc_dev;
            end
            m_flags <= ((m_flags & ~t_clr) | t_e) & IMPL_BITS;
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("status", reg_rdata, m_flags);
            chk("requests", {sci_req, smi_req, serr_req}, m_req);
            chk("log_addr", log_addr, m_addr);
            chk("log_dev", log_dev, m_dev);
        end
    end

    task automatic step(input logic [15:0] e, input logic w, input logic [15:0] d,
                        input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        evt_in = e; reg_wr = w; reg_wdata = d; ecc_addr = a; ecc_dev = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(16'h0, 1'b0, 16'h0, '0, '0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports.
        cur_req = "R1";
        chk("reset status", reg_rdata, 0);
        chk("reset req", {sci_req, smi_req, serr_req}, 0);
        chk("reset log", log_addr, 0);
        idle(2);

        // R2 R4: every position with all masks off; reserved events ignored.
        cur_req = "R2";
        for (int b = 0; b < 16; b++) begin
            step(16'h1 << b, 1'b0, 16'h0, 32'h1000 + b, 4'(b));
            idle(1);
        end
        cur_req = "R4";
        idle(3);
        chk("sticky all", reg_rdata, IMPL_BITS);

        // R3: zero writes keep, one writes clear.
        cur_req = "R3";
        step(16'h0, 1'b1, 16'h0000, '0, '0); idle(1);
        chk("write0 keeps", reg_rdata, IMPL_BITS);
        step(16'h0, 1'b1, 16'h0230, '0, '0); idle(1);
        chk("partial clear", reg_rdata, 16'h004F);
        step(16'h0, 1'b1, 16'hFFFF, '0, '0); idle(1);
        chk("full clear", reg_rdata, 0);

        // R6: three masks route independently; repeat event gives no pulse.
        cur_req = "R6";
        serr_en = 16'h0200; smi_en = 16'h0020; sci_en = 16'h0044;
        step(16'h0200, 1'b0, 16'h0, '0, '0);
        step(16'h0, 1'b0, 16'h0, '0, '0);
        chk("serr pulse", {sci_req, smi_req, serr_req}, 3'b001);
        step(16'h0200, 1'b0, 16'h0, '0, '0);
        step(16'h0, 1'b0, 16'h0, '0, '0);
        chk("no repeat pulse", {sci_req, smi_req, serr_req}, 3'b000);
        step(16'h0064, 1'b0, 16'h0, '0, '0);
        step(16'h0, 1'b0, 16'h0, '0, '0);
        chk("smi+sci pulse", {sci_req, smi_req, serr_req}, 3'b110);
        idle(1);
        chk("pulse one cycle", {sci_req, smi_req, serr_req}, 3'b000);

        // R5: event races a clear of the same bit.
        cur_req = "R5";
        step(16'h0040, 1'b1, 16'h0040, '0, '0);
        step(16'h0, 1'b0, 16'h0, '0, '0);
        chk("event wins", reg_rdata[6], 1);
        chk("no edge on set flag", sci_req, 0);
        step(16'h0, 1'b1, 16'hFFFF, '0, '0); idle(1);

        // R7 R8: log ordering.
        cur_req = "R8";
        step(16'h0001, 1'b0, 16'h0, 32'hA0, 4'h1); idle(1);
        chk("sbe capture", log_addr, 32'hA0);
        step(16'h0001, 1'b0, 16'h0, 32'hB0, 4'h2); idle(1);
        chk("sbe replaces sbe", log_addr, 32'hB0);
        cur_req = "R7";
        step(16'h0002, 1'b0, 16'h0, 32'hC0, 4'h3); idle(1);
        chk("mbe replaces sbe", log_addr, 32'hC0);
        step(16'h0002, 1'b0, 16'h0, 32'hD0, 4'h4); idle(1);
        chk("mbe locked", log_addr, 32'hC0);
        step(16'h0001, 1'b0, 16'h0, 32'hE0, 4'h5); idle(1);
        chk("sbe locked", log_dev, 4'h3);
        step(16'h0, 1'b1, 16'h0002, '0, '0); idle(1);
        step(16'h0001, 1'b0, 16'h0, 32'hF0, 4'h6); idle(1);
        chk("unlocked", log_addr, 32'hF0);
        cur_req = "R8";
        step(16'h0003, 1'b0, 16'h0, 32'h77, 4'h7); idle(1);
        chk("same-cycle mbe logs", log_dev, 4'h7);
        step(16'h0, 1'b1, 16'hFFFF, '0, '0); idle(1);

        // R9: sparse random traffic, model compared every cycle.
        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4 == 0) ? 16'($urandom) : 16'h0,
                 ($urandom % 5 == 0), 16'($urandom), 32'($urandom), 4'($urandom));
            if (i % 50 == 0) begin
                serr_en = 16'($urandom); smi_en = 16'($urandom); sci_en = 16'($urandom);
            end
        end
        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule